// File: doc/BRIEF.md
# Add-Compare-Select Array with Best-State Search

This block is the path-metric engine of a Viterbi decoder for the constraint-length-7, rate-1/2 convolutional code with generators 171 and 133 (octal). It keeps one accumulated metric for each of the 64 trellis states. On every accepted step it adds the four incoming branch metrics to the predecessor metrics and compares the two candidate paths entering each state. It keeps the cheaper path and emits one decision bit per state. All 64 state units work in parallel. A code that uses the two generators in the opposite order is decoded by exchanging the two received symbol streams before the branch-metric stage. The logic of this block does not change for that case.

Each step also reports which state holds the smallest metric, so a traceback unit can start from that state. When every metric has grown past half of its range, all metrics are rescaled together and a one-cycle normalization pulse is emitted. The rate of these pulses serves as an indicator of link quality and of synchronization.

A small two-state sequencer controls output timing. In state WAIT no result is presented. In state EMIT the registered result of the last accepted step is presented. The sequencer goes from WAIT to EMIT when a step is accepted, stays in EMIT while steps continue to be accepted, and returns from EMIT to WAIT when `in_valid` is low.

Top module: `acs_array`

## Requirements
- R1: After reset, `out_valid` and `norm_pulse` are 0. State 0 holds metric 0 and every other state holds INIT (default 256), so the first step's results follow from those values.
- R2: Next state n is reached from the even predecessor {n[4:0],0} and the odd predecessor {n[4:0],1}, and the input bit is n[5]. The 7-bit encoder word of a branch is {n, j}, where j is the low predecessor bit. Its first code bit c0 is the parity of that word ANDed with 7'o171, and its second code bit c1 is the parity of that word ANDed with 7'o133. The branch uses the metric at slice index {c0,c1} of `bm_in`, where slice k occupies bits [k*BM_W +: BM_W].
- R3: The new metric of each state is the smaller of its two candidate sums. Bit n of `dec_out` is 1 only when the odd predecessor's sum is strictly smaller. On a tie the even predecessor is kept and the bit is 0.
- R4: The results of a step accepted at a clock edge are visible after that edge, with `out_valid` high. `out_valid` is low in every cycle that follows an edge where `in_valid` was low.
- R5: While `in_valid` is low, the state metrics do not change.
- R6: If every metric has its MSB set when a step is accepted, the MSB of all metrics is cleared before the add, and `norm_pulse` is high together with that step's `out_valid`. Otherwise `norm_pulse` is low.
- R7: `best_state` is the index of the smallest new metric. On a tie the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Step strobe for `bm_in` |
| bm_in | input | 4*BM_W | Four branch metrics, slice {c0,c1} |
| out_valid | output | 1 | Result of an accepted step is present |
| dec_out | output | 64 | Survivor decision per state |
| best_state | output | 6 | Index of the minimum-metric state |
| norm_pulse | output | 1 | Metrics were rescaled this step |

## Verification
All three results of a step (decisions, best state, normalization flag) are due in the same cycle, one register stage after the edge that accepts the step. The bench drives each step at a falling edge and checks the outputs at the next falling edge, after the accepting rising edge. That keeps every comparison half a clock away from an active edge. Idle cycles are checked in the same slot for a low `out_valid`. The metrics that were held across an idle cycle are then checked through the results of the following step.

// File: rtl/acs_pkg.sv
package acs_pkg;
    localparam int CONSTR   = 7;
    localparam int SBITS    = CONSTR - 1;
    localparam int NSTATES  = 1 << SBITS;
    localparam logic [CONSTR-1:0] TAP_A = 7'o171;
    localparam logic [CONSTR-1:0] TAP_B = 7'o133;

    typedef enum logic {S_WAIT, S_EMIT} phase_t;

    // expected code pair {c0,c1} of the branch from predecessor {nxt[4:0],j} into nxt
    function automatic logic [1:0] branch_code(input logic [SBITS-1:0] nxt, input logic j);
        logic [CONSTR-1:0] word;
        word = {nxt, j};
        return {^(word & TAP_A), ^(word & TAP_B)};
    endfunction
endpackage

// File: rtl/acs_node.sv
module acs_node
    import acs_pkg::*;
#(
    parameter int PM_W = 10,
    parameter int BM_W = 4
) (
    input  logic [PM_W-1:0] pm_even,
    input  logic [PM_W-1:0] pm_odd,
    input  logic [BM_W-1:0] bm_even,
    input  logic [BM_W-1:0] bm_odd,
    input  logic            rescale,
    output logic [PM_W-1:0] pm_new,
    output logic            pick_odd
);
    localparam logic [PM_W-1:0] MSB_MASK = {1'b0, {(PM_W-1){1'b1}}};

    logic [PM_W-1:0] base_e, base_o;
    logic [PM_W:0]   sum_e, sum_o;
    logic [PM_W-1:0] cap_e, cap_o;

    always_comb begin
        base_e = rescale ? (pm_even & MSB_MASK) : pm_even;
        base_o = rescale ? (pm_odd  & MSB_MASK) : pm_odd;
        sum_e  = {1'b0, base_e} + {{(PM_W+1-BM_W){1'b0}}, bm_even};
        sum_o  = {1'b0, base_o} + {{(PM_W+1-BM_W){1'b0}}, bm_odd};
        cap_e  = sum_e[PM_W] ? {PM_W{1'b1}} : sum_e[PM_W-1:0];
        cap_o  = sum_o[PM_W] ? {PM_W{1'b1}} : sum_o[PM_W-1:0];
        pick_odd = (cap_o < cap_e);
        pm_new   = pick_odd ? cap_o : cap_e;
    end
endmodule

// File: rtl/best_finder.sv
module best_finder
    import acs_pkg::*;
#(
    parameter int PM_W = 10
) (
    input  logic [NSTATES*PM_W-1:0] metrics,
    output logic [SBITS-1:0]        min_idx
);
    logic [PM_W-1:0] cur;
    always_comb begin
        min_idx = '0;
        cur     = metrics[PM_W-1:0];
        for (int i = 1; i < NSTATES; i++) begin
            if (metrics[i*PM_W +: PM_W] < cur) begin
                cur     = metrics[i*PM_W +: PM_W];
                min_idx = SBITS'(i);
            end
        end
    end
endmodule

// File: rtl/acs_array.sv
module acs_array
    import acs_pkg::*;
#(
    parameter int PM_W = 10,
    parameter int BM_W = 4,
    parameter int INIT = 1 << (PM_W - 2)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [4*BM_W-1:0]    bm_in,
    output logic                 out_valid,
    output logic [NSTATES-1:0]   dec_out,
    output logic [SBITS-1:0]     best_state,
    output logic                 norm_pulse
);
    localparam logic [PM_W-1:0] INIT_PM = PM_W'(INIT);

    phase_t phase_q, phase_d;

    logic [NSTATES*PM_W-1:0] pm_flat;
    logic [NSTATES*PM_W-1:0] pm_next;
    logic [NSTATES-1:0]      dec_next;
    logic [NSTATES-1:0]      msb_vec;
    logic                    rescale;
    logic [SBITS-1:0]        best_next;

    for (genvar s = 0; s < NSTATES; s++) begin : g_msb
        assign msb_vec[s] = pm_flat[s*PM_W + PM_W - 1];
    end
    assign rescale = &msb_vec;

    for (genvar n = 0; n < NSTATES; n++) begin : g_node
        localparam int PE = (n << 1) & (NSTATES - 1);
        localparam int PO = PE | 1;
        localparam logic [1:0] CE = branch_code(SBITS'(n), 1'b0);
        localparam logic [1:0] CO = branch_code(SBITS'(n), 1'b1);
        acs_node #(.PM_W(PM_W), .BM_W(BM_W)) u_node (
            .pm_even (pm_flat[PE*PM_W +: PM_W]),
            .pm_odd  (pm_flat[PO*PM_W +: PM_W]),
            .bm_even (bm_in[int'(CE)*BM_W +: BM_W]),
            .bm_odd  (bm_in[int'(CO)*BM_W +: BM_W]),
            .rescale (rescale),
            .pm_new  (pm_next[n*PM_W +: PM_W]),
            .pick_odd(dec_next[n])
        );
    end

    best_finder #(.PM_W(PM_W)) u_best (
        .metrics(pm_next),
        .min_idx(best_next)
    );

    // sequencer: next phase
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            S_WAIT: phase_d = in_valid ? S_EMIT : S_WAIT;
            S_EMIT: phase_d = in_valid ? S_EMIT : S_WAIT;
            default: phase_d = S_WAIT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) phase_q <= S_WAIT;
        else     phase_q <= phase_d;
    end

    // metrics and step results
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSTATES; s++)
                pm_flat[s*PM_W +: PM_W] <= (s == 0) ? '0 : INIT_PM;
            dec_out    <= '0;
            best_state <= '0;
            norm_pulse <= 1'b0;
        end else if (in_valid) begin
            pm_flat    <= pm_next;
            dec_out    <= dec_next;
            best_state <= best_next;
            norm_pulse <= rescale;
        end else begin
            norm_pulse <= 1'b0;
        end
    end

    assign out_valid = (phase_q == S_EMIT);
endmodule

// File: rtl/acs_array_chk.sv
module acs_array_chk
    import acs_pkg::*;
#(
    parameter int PM_W = 10
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     out_valid,
    input logic                     norm_pulse,
    input logic [SBITS-1:0]         best_state,
    input logic [NSTATES*PM_W-1:0]  pm_flat
);
    logic best_bad;
    logic sat_any;
    logic [PM_W-1:0] bval;

    always_comb begin
        best_bad = 1'b0;
        sat_any  = 1'b0;
        bval     = pm_flat[int'(best_state)*PM_W +: PM_W];
        for (int i = 0; i < NSTATES; i++) begin
            if (pm_flat[i*PM_W +: PM_W] < bval) best_bad = 1'b1;
            if (i < int'(best_state) && pm_flat[i*PM_W +: PM_W] == bval) best_bad = 1'b1;
            if (pm_flat[i*PM_W +: PM_W] == {PM_W{1'b1}}) sat_any = 1'b1;
        end
    end

    a_r7_best_is_min: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !best_bad);
    a_r6_norm_with_valid: assert property (@(posedge clk) disable iff (rst)
        norm_pulse |-> out_valid);
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        !sat_any);
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(pm_flat));
    a_r4_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r4_no_stray_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
endmodule

bind acs_array acs_array_chk #(.PM_W(PM_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .norm_pulse(norm_pulse), .best_state(best_state), .pm_flat(pm_flat)
);

// File: tb/acs_array_bench.sv
module acs_array_bench;
    localparam int PM_W = 10;
    localparam int BM_W = 4;
    localparam int INIT = 256;
    localparam int NS   = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [4*BM_W-1:0] bm_in = '0;
    logic              out_valid;
    logic [NS-1:0]     dec_out;
    logic [5:0]        best_state;
    logic              norm_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    int m [NS];
    logic [NS-1:0] e_dec;
    int  e_best;
    bit  e_norm;
    int  norm_seen = 0;

    // stimulus table: {valid, bm11, bm10, bm01, bm00}
    localparam logic [16:0] VEC [16] = '{
        17'h1_F0A3, 17'h1_0F3A, 17'h1_2468, 17'h0_0000,
        17'h1_8421, 17'h1_1248, 17'h1_7777, 17'h1_E1D2,
        17'h0_0000, 17'h1_05A0, 17'h1_A050, 17'h1_3C3C,
        17'h1_C3C3, 17'h1_0F0F, 17'h1_F00F, 17'h1_9B6D
    };

    always #2 clk = ~clk;

    acs_array #(.PM_W(PM_W), .BM_W(BM_W), .INIT(INIT)) u_acs_array (
        .clk(clk), .rst(rst), .in_valid(in_valid), .bm_in(bm_in),
        .out_valid(out_valid), .dec_out(dec_out), .best_state(best_state),
        .norm_pulse(norm_pulse)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int parity7(input int word, input int taps);
        int c = 0;
        for (int b = 0; b < 7; b++) if (((word >> b) & 1) && ((taps >> b) & 1)) c++;
        return c & 1;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < NS; s++) m[s] = (s == 0) ? 0 : INIT;
    endtask

    // reference step written from R2, R3, R6, R7
    task automatic model_step(input logic [4*BM_W-1:0] bm);
        int nm [NS];
        bit all_hi = 1'b1;
        for (int s = 0; s < NS; s++) if (m[s] < 512) all_hi = 1'b0;
        if (all_hi) for (int s = 0; s < NS; s++) m[s] -= 512;
        e_norm = all_hi;
        for (int n = 0; n < NS; n++) begin
            int ce, co, se, so;
            ce = parity7(n*2, 'o171)*2 + parity7(n*2, 'o133);
            co = parity7(n*2+1, 'o171)*2 + parity7(n*2+1, 'o133);
            se = m[(n*2) % NS]   + int'(bm[ce*BM_W +: BM_W]);
            so = m[(n*2+1) % NS] + int'(bm[co*BM_W +: BM_W]);
            e_dec[n] = (so < se);
            nm[n] = (so < se) ? so : se;
        end
        e_best = 0;
        for (int n = 0; n < NS; n++) begin
            m[n] = nm[n];
            if (nm[n] < nm[e_best]) e_best = n;
        end
    endtask

    task automatic do_step(input logic [4*BM_W-1:0] bm, input string req);
        in_valid = 1'b1;
        bm_in    = bm;
        model_step(bm);
        @(posedge clk);
        @(negedge clk);
        check("R4", "out_valid", longint'(out_valid), 1);
        check(req, "dec_out", longint'(dec_out), longint'(e_dec));
        check("R7", "best_state", longint'(best_state), longint'(e_best));
        check("R6", "norm_pulse", longint'(norm_pulse), longint'(e_norm));
        if (norm_pulse) norm_seen++;
    endtask

    task automatic do_idle();
        in_valid = 1'b0;
        bm_in    = 16'hFFFF;
        @(posedge clk);
        @(negedge clk);
        check("R5", "out_valid idle", longint'(out_valid), 0);
        check("R6", "norm idle", longint'(norm_pulse), 0);
    endtask

    initial begin
        #400000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check("R1", "out_valid reset", longint'(out_valid), 0);
        check("R1", "norm reset", longint'(norm_pulse), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "out_valid after reset", longint'(out_valid), 0);

        // first step follows from the reset metrics
        do_step(16'h3210, "R1");

        // table walk
        for (int i = 0; i < 48; i++) begin
            if (VEC[i % 16][16]) do_step(VEC[i % 16][15:0], "R2");
            else                 do_idle();
        end

        // long idle, then a step proves the metrics were held
        repeat (5) do_idle();
        do_step(16'h5A5A, "R5");

        // equal branch metrics: metrics climb until rescaled
        for (int i = 0; i < 90; i++) do_step(16'hFFFF, "R6");
        check("R6", "normalization count>0", longint'(norm_seen > 0), 1);

        // all metrics equal: ties keep even predecessor, best is state 0
        do_step(16'h1111, "R3");
        check("R3", "tie decisions", longint'(dec_out), 0);
        check("R7", "tie best index", longint'(best_state), 0);

        // asymmetric metric to force odd picks
        for (int i = 0; i < 8; i++) do_step(16'h0F00 + 16'(i), "R3");

        // mid-run reset
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R1", "out_valid in reset", longint'(out_valid), 0);
        rst = 1'b0;
        model_reset();
        do_step(16'hC0DE, "R1");
        do_step(16'h0000, "R3");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule